// File: doc/BRIEF.md
# Shift and Rotate Unit with Quotient-Side Register

This block runs the older family of 32-bit shift and rotate operations that keep a side register beside the general register file. The side register is called the quotient register here. One datapath serves all of them. Each operation takes a source word, the current destination word and a shift-amount word, or a 5-bit immediate in place of the shift-amount word. It produces a new destination word. It may also reload the quotient register with a rotated copy of the source, merge the old quotient register into the result under a mask, or produce a carry for the algebraic right shifts.

Instruction decode and the register file sit outside. The block gets a decoded operation code, a record flag and the operands on a valid strobe. On the next rising clock edge it captures the destination result, the carry, the condition field and the new quotient register value. All of these are captured on the same edge. Bit 5 of the shift-amount word selects the long forms. When the immediate is selected, that bit is taken as clear.

Top module: `shq_unit`

## Requirements
- R1: The shift amount n is `rb_i[4:0]`, or `imm_i` when `use_imm_i` is 1. The long bit is `rb_i[5]`, and it is forced to 0 when `use_imm_i` is 1. Operation codes on `op_i`: 0 sle, 1 sre, 2 sleq, 3 sreq, 4 sllq, 5 srlq, 6 slq, 7 srq, 8 sraq, 9 srea, 10 rlmi, 11 rrib.
- R2: sle gives ra = rs << n and loads the quotient register with rs rotated left by n. sre gives ra = rs >> n (logical) and loads rs rotated right by n.
- R3: sleq and sreq use M = ones << n for left and ones >> n for right, and R = rs rotated by n in the same direction. They give ra = (R & M) | (oldq & ~M) and load R.
- R4: sllq and srlq leave the quotient register unchanged. With the long bit clear: ra = (rs shifted by n & M) | (oldq & ~M). With the long bit set: ra = oldq & M.
- R5: slq and srq load rs rotated by n in the direction of the shift. ra = rs shifted by n, or 0 when the long bit is set.
- R6: sraq loads rs rotated right by n. ra = rs arithmetically shifted right by n. When the long bit is set, ra is the sign of rs copied into all 32 bits.
- R7: sraq sets the carry to 1 only when rs is negative and a 1 bit was shifted out. With the long bit set, every bit counts as shifted out. All other operations leave the carry unchanged.
- R8: srea gives ra = rs arithmetically shifted right by n and loads rs rotated right by n. The carry is not touched.
- R9: rlmi rotates rs left by n and inserts it into ra_i under a mask. The mask covers bit positions mb_i through me_i, where position 0 is the MSB. The mask wraps through position 31 back to 0 when mb_i > me_i. This operation does not change the quotient register.
- R10: rrib copies the bit at MSB-index n of (rs >> n) into ra_i. All other bits of ra_i are kept. The quotient register is unchanged.
- R11: When `rec_i` is 1, cr0_o = {lt, gt, eq}, a signed comparison of the new ra against zero: bit 2 is less-than, bit 1 is greater-than, bit 0 is equal. When `rec_i` is 0, cr0_o holds its value.
- R12: All outputs are registered and change on the rising edge after a cycle with `valid_i` = 1. They hold while `valid_i` = 0. Reset clears all outputs and the quotient register to 0.
- R13: Operation codes 12 to 15 give ra = ra_i and leave the quotient register and the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| rec_i | input | 1 | Update the condition field |
| use_imm_i | input | 1 | Take the shift amount from imm_i |
| imm_i | input | 5 | Immediate shift amount |
| mb_i | input | 5 | Rotate-insert mask start (MSB = 0) |
| me_i | input | 5 | Rotate-insert mask end (MSB = 0) |
| rs_i | input | 32 | Source word |
| ra_i | input | 32 | Current destination word |
| rb_i | input | 32 | Shift-amount word |
| ra_o | output | 32 | Registered destination result |
| ca_o | output | 1 | Registered carry |
| cr0_o | output | 3 | Registered {lt, gt, eq} condition field |
| mq_o | output | 32 | Quotient register |

## Verification
Random operands are applied to all sixteen operation codes. Random amounts cover both states of the long bit and both amount sources. The quotient register carries over from one operation to the next, so any error in a merge or hold persists and shows up in later results. Directed cases cover the following:
- Amount 0 and amount 31, which separate the rotate edges from the plain shift.
- A negative source whose shifted-out bits are all zero, which separates a carry computed from the sign alone from the correct rule.
- Mask bounds with mb > me, mb = me and mb = 0/me = 31, which exercise the wrapped mask.
- Idle cycles and records with the flag clear, which show that the registered outputs hold.

// File: rtl/shq_pkg.sv
package shq_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = $clog2(DW);

  typedef enum logic [3:0] {
    OP_SLE  = 4'd0,
    OP_SRE  = 4'd1,
    OP_SLEQ = 4'd2,
    OP_SREQ = 4'd3,
    OP_SLLQ = 4'd4,
    OP_SRLQ = 4'd5,
    OP_SLQ  = 4'd6,
    OP_SRQ  = 4'd7,
    OP_SRAQ = 4'd8,
    OP_SREA = 4'd9,
    OP_RLMI = 4'd10,
    OP_RRIB = 4'd11,
    OP_R12  = 4'd12,
    OP_R13  = 4'd13,
    OP_R14  = 4'd14,
    OP_R15  = 4'd15
  } shq_op_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } shq_cr_t;
endpackage

// File: rtl/shq_rotator.sv
// Logarithmic rotator; LEFT selects the direction at elaboration.
module shq_rotator #(
  parameter int unsigned W    = 32,
  parameter bit          LEFT = 1'b1,
  localparam int unsigned SW  = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] stage [SW+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    logic [W-1:0] rot;
    if (LEFT) begin : g_left
      assign rot = {stage[k][W-1-S:0], stage[k][W-1:W-S]};
    end else begin : g_right
      assign rot = {stage[k][S-1:0], stage[k][W-1:S]};
    end
    assign stage[k+1] = amt_i[k] ? rot : stage[k];
  end

  assign data_o = stage[SW];
endmodule

// File: rtl/shq_mask_gen.sv
// Shift masks, the single-bit insert mask and the wrapping field mask.
module shq_mask_gen #(
  parameter int unsigned W   = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [SW-1:0] amt_i,
  input  logic [SW-1:0] mb_i,
  input  logic [SW-1:0] me_i,
  output logic [W-1:0]  ml_o,
  output logic [W-1:0]  mr_o,
  output logic [W-1:0]  bit_o,
  output logic [W-1:0]  fld_o
);
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] TOP  = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] from_mb;
  logic [W-1:0] to_me;
  logic [SW-1:0] me_lsb;

  assign me_lsb  = SW'(W - 1) - me_i;
  assign ml_o    = ONES << amt_i;
  assign mr_o    = ONES >> amt_i;
  assign bit_o   = TOP >> amt_i;
  assign from_mb = ONES >> mb_i;
  assign to_me   = ONES << me_lsb;

  always_comb begin
    if (mb_i <= me_i) fld_o = from_mb & to_me;
    else              fld_o = from_mb | to_me;
  end
endmodule

// File: rtl/shq_core.sv
// Combinational result, quotient-register and carry selection.
module shq_core #(
  parameter int unsigned W   = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  shq_pkg::shq_op_e op_i,
  input  logic [W-1:0]     rs_i,
  input  logic [W-1:0]     ra_i,
  input  logic [W-1:0]     mq_i,
  input  logic [SW-1:0]    amt_i,
  input  logic             long_i,
  input  logic [SW-1:0]    mb_i,
  input  logic [SW-1:0]    me_i,
  output logic [W-1:0]     res_o,
  output logic [W-1:0]     mq_nx_o,
  output logic             mq_we_o,
  output logic             ca_nx_o,
  output logic             ca_we_o
);
  import shq_pkg::*;

  logic [W-1:0] rotl, rotr, ml, mr, bm, fm;
  logic [W-1:0] shl, shr, sra;
  logic         sign;

  shq_rotator #(.W(W), .LEFT(1'b1)) u_rotl (.data_i(rs_i), .amt_i(amt_i), .data_o(rotl));
  shq_rotator #(.W(W), .LEFT(1'b0)) u_rotr (.data_i(rs_i), .amt_i(amt_i), .data_o(rotr));

  shq_mask_gen #(.W(W)) u_mask (
    .amt_i(amt_i), .mb_i(mb_i), .me_i(me_i),
    .ml_o(ml), .mr_o(mr), .bit_o(bm), .fld_o(fm)
  );

  assign sign = rs_i[W-1];
  assign shl  = rotl & ml;
  assign shr  = rotr & mr;
  assign sra  = shr | ({W{sign}} & ~mr);

  always_comb begin
    res_o   = ra_i;
    mq_nx_o = mq_i;
    mq_we_o = 1'b0;
    ca_nx_o = 1'b0;
    ca_we_o = 1'b0;
    unique case (op_i)
      OP_SLE: begin
        res_o = shl; mq_nx_o = rotl; mq_we_o = 1'b1;
      end
      OP_SRE: begin
        res_o = shr; mq_nx_o = rotr; mq_we_o = 1'b1;
      end
      OP_SLEQ: begin
        res_o = (rotl & ml) | (mq_i & ~ml); mq_nx_o = rotl; mq_we_o = 1'b1;
      end
      OP_SREQ: begin
        res_o = (rotr & mr) | (mq_i & ~mr); mq_nx_o = rotr; mq_we_o = 1'b1;
      end
      OP_SLLQ: begin
        res_o = long_i ? (mq_i & ml) : (shl | (mq_i & ~ml));
      end
      OP_SRLQ: begin
        res_o = long_i ? (mq_i & mr) : (shr | (mq_i & ~mr));
      end
      OP_SLQ: begin
        res_o = long_i ? '0 : shl; mq_nx_o = rotl; mq_we_o = 1'b1;
      end
      OP_SRQ: begin
        res_o = long_i ? '0 : shr; mq_nx_o = rotr; mq_we_o = 1'b1;
      end
      OP_SRAQ: begin
        res_o   = long_i ? {W{sign}} : sra;
        mq_nx_o = rotr;
        mq_we_o = 1'b1;
        ca_we_o = 1'b1;
        ca_nx_o = sign & (long_i ? (|rs_i) : (|(rs_i & ~ml)));
      end
      OP_SREA: begin
        res_o = sra; mq_nx_o = rotr; mq_we_o = 1'b1;
      end
      OP_RLMI: res_o = (rotl & fm) | (ra_i & ~fm);
      OP_RRIB: res_o = (rotr & bm) | (ra_i & ~bm);
      default: res_o = ra_i;
    endcase
  end
endmodule

// File: rtl/shq_unit.sv
module shq_unit #(
  parameter int unsigned W   = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic          rec_i,
  input  logic          use_imm_i,
  input  logic [SW-1:0] imm_i,
  input  logic [SW-1:0] mb_i,
  input  logic [SW-1:0] me_i,
  input  logic [W-1:0]  rs_i,
  input  logic [W-1:0]  ra_i,
  input  logic [W-1:0]  rb_i,
  output logic [W-1:0]  ra_o,
  output logic          ca_o,
  output logic [2:0]    cr0_o,
  output logic [W-1:0]  mq_o
);
  import shq_pkg::*;

  // reset synchronizer: asserts at once, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  shq_op_e       op;
  logic [SW-1:0] amt;
  logic          long_bit;
  logic [W-1:0]  res, mq_nx;
  logic          mq_we, ca_nx, ca_we;
  shq_cr_t       cr_nx;

  assign op       = shq_op_e'(op_i);
  assign amt      = use_imm_i ? imm_i : rb_i[SW-1:0];
  assign long_bit = ~use_imm_i & rb_i[SW];

  shq_core #(.W(W)) u_core (
    .op_i(op), .rs_i(rs_i), .ra_i(ra_i), .mq_i(mq_o),
    .amt_i(amt), .long_i(long_bit), .mb_i(mb_i), .me_i(me_i),
    .res_o(res), .mq_nx_o(mq_nx), .mq_we_o(mq_we),
    .ca_nx_o(ca_nx), .ca_we_o(ca_we)
  );

  always_comb begin
    cr_nx.lt = res[W-1];
    cr_nx.eq = (res == '0);
    cr_nx.gt = ~cr_nx.lt & ~cr_nx.eq;
  end

  // clock enables
  logic ra_en, mq_en, ca_en, cr_en;
  assign ra_en = valid_i;
  assign mq_en = valid_i & mq_we;
  assign ca_en = valid_i & ca_we;
  assign cr_en = valid_i & rec_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ra_o  <= '0;
      mq_o  <= '0;
      ca_o  <= 1'b0;
      cr0_o <= 3'b000;
    end else begin
      if (ra_en) ra_o  <= res;
      if (mq_en) mq_o  <= mq_nx;
      if (ca_en) ca_o  <= ca_nx;
      if (cr_en) cr0_o <= cr_nx;
    end
  end

  // R12: idle cycles hold every output
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    !valid_i |=> ($stable(ra_o) && $stable(mq_o) && $stable(ca_o) && $stable(cr0_o)));

  // R4: long-with-quotient forms keep the quotient register
  p_long_keeps_q_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd4 || op_i == 4'd5)) |=> $stable(mq_o));

  // R5: long quotient shifts with the long bit set give zero
  p_long_zero_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd6 || op_i == 4'd7) && !use_imm_i && rb_i[5]) |=> (ra_o == '0));

  // R6: long algebraic form fills with the sign
  p_sign_fill_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_i && op_i == 4'd8 && !use_imm_i && rb_i[5]) |=> (ra_o == {W{$past(rs_i[W-1])}}));

  // R7: a non-negative source never produces a carry
  p_pos_no_carry_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_i && op_i == 4'd8 && !rs_i[W-1]) |=> !ca_o);

  // R11: condition field is one-hot after a record and matches the result
  p_cr_match_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_i && rec_i) |=> ($onehot(cr0_o) && (cr0_o[0] == (ra_o == '0)) && (cr0_o[2] == ra_o[W-1])));

  // R13: reserved codes pass the destination through
  p_reserved_pass_r13: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_i && op_i >= 4'd12) |=> (ra_o == $past(ra_i) && $stable(mq_o) && $stable(ca_o)));
endmodule

// File: tb/shq_unit_tb.sv
module shq_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, rec_i, use_imm_i;
  logic [3:0]  op_i;
  logic [4:0]  imm_i, mb_i, me_i;
  logic [31:0] rs_i, ra_i, rb_i;
  logic [31:0] ra_o, mq_o;
  logic        ca_o;
  logic [2:0]  cr0_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_ra, m_mq;
  logic        m_ca;
  logic [2:0]  m_cr;

  always #(CLK_PERIOD/2) clk = ~clk;

  shq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .rec_i(rec_i),
    .use_imm_i(use_imm_i), .imm_i(imm_i), .mb_i(mb_i), .me_i(me_i),
    .rs_i(rs_i), .ra_i(ra_i), .rb_i(rb_i),
    .ra_o(ra_o), .ca_o(ca_o), .cr0_o(cr0_o), .mq_o(mq_o)
  );

  function automatic logic [31:0] f_rotl(logic [31:0] x, int n);
    logic [63:0] t;
    t = {x, x} << n;
    return t[63:32];
  endfunction

  function automatic logic [31:0] f_rotr(logic [31:0] x, int n);
    logic [63:0] t;
    t = {x, x} >> n;
    return t[31:0];
  endfunction

  function automatic logic [31:0] f_field(int mb, int me);
    logic [31:0] m;
    for (int p = 0; p < 32; p++) begin
      if (mb <= me) m[31-p] = (p >= mb) && (p <= me);
      else          m[31-p] = (p >= mb) || (p <= me);
    end
    return m;
  endfunction

  function automatic string f_req(int op);
    case (op)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5:    return "R4";
      6, 7:    return "R5";
      8:       return "R6";
      9:       return "R8";
      10:      return "R9";
      11:      return "R10";
      default: return "R13";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // reference model, updates m_* state
  task automatic model(int op, logic rec, logic uimm, logic [4:0] imm, logic [4:0] mb,
                       logic [4:0] me, logic [31:0] rs, logic [31:0] ra, logic [31:0] rb);
    int n;
    logic lng;
    logic [31:0] ml, mr, r, q, bm, fm;
    n   = uimm ? int'(imm) : int'(rb[4:0]);
    lng = !uimm && rb[5];
    ml  = 32'hFFFF_FFFF << n;
    mr  = 32'hFFFF_FFFF >> n;
    q   = m_mq;
    r   = ra;
    case (op)
      0: begin r = rs << n; q = f_rotl(rs, n); end
      1: begin r = rs >> n; q = f_rotr(rs, n); end
      2: begin r = (f_rotl(rs, n) & ml) | (m_mq & ~ml); q = f_rotl(rs, n); end
      3: begin r = (f_rotr(rs, n) & mr) | (m_mq & ~mr); q = f_rotr(rs, n); end
      4: r = lng ? (m_mq & ml) : ((rs << n) | (m_mq & ~ml));
      5: r = lng ? (m_mq & mr) : ((rs >> n) | (m_mq & ~mr));
      6: begin r = lng ? 32'd0 : rs << n; q = f_rotl(rs, n); end
      7: begin r = lng ? 32'd0 : rs >> n; q = f_rotr(rs, n); end
      8: begin
        r = lng ? {32{rs[31]}} : 32'($signed(rs) >>> n);
        q = f_rotr(rs, n);
        if (!rs[31]) m_ca = 1'b0;
        else if (lng) m_ca = 1'b1;
        else m_ca = ((rs & ~ml) != 32'd0);
      end
      9: begin r = 32'($signed(rs) >>> n); q = f_rotr(rs, n); end
      10: begin fm = f_field(int'(mb), int'(me)); r = (f_rotl(rs, n) & fm) | (ra & ~fm); end
      11: begin bm = 32'h8000_0000 >> n; r = ((rs >> n) & bm) | (ra & ~bm); end
      default: r = ra;
    endcase
    m_ra = r;
    m_mq = q;
    if (rec) m_cr = r[31] ? 3'b100 : (r == 0 ? 3'b001 : 3'b010);
  endtask

  task automatic compare_all(string req);
    check(req, "ra", ra_o, m_ra);
    check(req, "mq", mq_o, m_mq);
    check((req == "R6") ? "R7" : req, "ca", {31'd0, ca_o}, {31'd0, m_ca});
    check("R11", "cr0", {29'd0, cr0_o}, {29'd0, m_cr});
  endtask

  // drive at negedge, check at the following negedge
  task automatic run_op(int op, logic rec, logic uimm, logic [4:0] imm, logic [4:0] mb,
                        logic [4:0] me, logic [31:0] rs, logic [31:0] ra, logic [31:0] rb);
    valid_i = 1'b1; op_i = 4'(op); rec_i = rec; use_imm_i = uimm; imm_i = imm;
    mb_i = mb; me_i = me; rs_i = rs; ra_i = ra; rb_i = rb;
    model(op, rec, uimm, imm, mb, me, rs, ra, rb);
    @(negedge clk);
    valid_i = 1'b0;
    compare_all(f_req(op));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; valid_i = 0; op_i = 0; rec_i = 0; use_imm_i = 0; imm_i = 0;
    mb_i = 0; me_i = 0; rs_i = 0; ra_i = 0; rb_i = 0;
    m_ra = 0; m_mq = 0; m_ca = 0; m_cr = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "reset ra", ra_o, 32'd0);
    check("R12", "reset mq", mq_o, 32'd0);
    check("R12", "reset ca/cr", {28'd0, ca_o, cr0_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 amount 0 and 31
    run_op(0, 1, 0, 0, 0, 0, 32'hF000_000F, 0, 32'd0);
    run_op(0, 1, 0, 0, 0, 0, 32'h8000_0003, 0, 32'd31);
    run_op(1, 1, 0, 0, 0, 0, 32'h8000_0003, 0, 32'd31);
    // R1 immediate overrides rb and clears the long bit
    run_op(6, 1, 1, 5'd4, 0, 0, 32'h1234_5678, 0, 32'h0000_003F);
    run_op(0, 0, 1, 5'd8, 0, 0, 32'hAABB_CCDD, 0, 32'hFFFF_FFE3);
    // R3 merges
    run_op(2, 1, 0, 0, 0, 0, 32'hDEAD_BEEF, 0, 32'd12);
    run_op(3, 1, 0, 0, 0, 0, 32'h0F0F_1234, 0, 32'd20);
    // R4 long bit clear and set
    run_op(4, 1, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 32'd8);
    run_op(4, 1, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 32'h0000_0028);
    run_op(5, 1, 0, 0, 0, 0, 32'h1111_1111, 0, 32'h0000_0024);
    // R5 long zeroing
    run_op(7, 1, 0, 0, 0, 0, 32'hFFFF_0000, 0, 32'h0000_0023);
    // R6/R7 carry corners
    run_op(8, 1, 0, 0, 0, 0, 32'h8000_0000, 0, 32'd4);   // negative, zeros out: ca 0
    run_op(8, 1, 0, 0, 0, 0, 32'h8000_0010, 0, 32'd5);   // negative, one out: ca 1
    run_op(9, 1, 0, 0, 0, 0, 32'h8000_0000, 0, 32'd31);  // R8 carry held
    run_op(8, 1, 0, 0, 0, 0, 32'h7FFF_FFFF, 0, 32'h0000_0021); // positive long
    run_op(8, 1, 0, 0, 0, 0, 32'hC000_0000, 0, 32'h0000_0020); // negative long
    // R9 mask wrap and edges
    run_op(10, 1, 0, 0, 5'd28, 5'd3, 32'h1234_5678, 32'hAAAA_AAAA, 32'd4);
    run_op(10, 1, 0, 0, 5'd7, 5'd7, 32'hFFFF_FFFF, 32'h0000_0000, 32'd0);
    run_op(10, 1, 0, 0, 5'd0, 5'd31, 32'h0000_00FF, 32'h5555_5555, 32'd28);
    // R10
    run_op(11, 1, 0, 0, 0, 0, 32'h8000_0000, 32'h0000_0000, 32'd9);
    run_op(11, 1, 0, 0, 0, 0, 32'h0000_0000, 32'hFFFF_FFFF, 32'd0);
    // R13 reserved codes
    run_op(13, 1, 0, 0, 0, 0, 32'h1234_5678, 32'hCAFE_0001, 32'd3);
    // R11 record clear keeps cr0
    run_op(0, 0, 0, 0, 0, 0, 32'h0000_0000, 0, 32'd1);
    // R12 idle cycles hold
    rs_i = 32'hFFFF_FFFF; rb_i = 32'd3; op_i = 4'd0; rec_i = 1'b1;
    @(negedge clk);
    compare_all("R12");

    for (int i = 0; i < 600; i++) begin
      int op;
      logic [31:0] rb;
      op = int'($urandom_range(0, 15));
      rb = $urandom;
      if (($urandom & 3) == 0) rb[4:0] = ($urandom & 1) ? 5'd0 : 5'd31;
      run_op(op, logic'($urandom & 1), logic'(($urandom & 3) == 0), 5'($urandom),
             5'($urandom), 5'($urandom), $urandom, $urandom, rb);
      if (($urandom & 7) == 0) begin
        rs_i = $urandom; rb_i = $urandom; op_i = 4'($urandom); rec_i = 1'b1;
        @(negedge clk);
        compare_all("R12");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule